// File: doc/BRIEF.md
# I/O Cycle Backplane Strobe Timer

This block paces a peripheral backplane through a repeating I/O cycle of five periods, T2, T3, T4, T5 and T6. Each period lasts a fixed number of clocks. In every cycle it pulses the flag-enable strobe (ENF) in T2 and the set-interrupt-request strobe (SIR) in T5, whether or not any transfer is taking place. When a cycle carries an operation, it also drives the data, control and flag strobes into the windows that belong to that kind of cycle.

Two kinds of operation exist. A processor cycle carries one programmed I/O instruction, and that instruction selects which strobes appear. A DMA cycle moves one word inbound or outbound and always clears the flag. It sets control only if the DMA control word allows it. A DMA cycle marked as the last one also signals end of transfer, and it may clear control. Several strobes can be active in the same period, so a card on the backplane can see them together. The caller places a request in a one-entry slot. The request is taken at the start of the next T2 and stays fixed until the end of T6.

Top module: `io_cycle_strobe_timer`

## Requirements
- R1: `t_phase` is one-hot, with bit 0 for T2, bit 1 for T3, bit 2 for T4, bit 3 for T5 and bit 4 for T6. Each period lasts PERIOD_CLKS clocks, and T6 is followed by T2 without end. After reset the block is in the first clock of T2 and that cycle carries no operation.
- R2: `enf` is high during all of T2 and `sir` is high during all of T5 in every cycle, whether or not an operation is active.
- R3: In a DMA cycle (`req_dma`=1), an inbound transfer (`req_dir_out`=0) drives `ioi` in T2 and T3, and an outbound transfer (`req_dir_out`=1) drives `ioo` in T3 and T4.
- R4: In every DMA cycle `clf` is high in T3. `stc` is high in T3 only when `req_stc_en`=1.
- R5: In a DMA cycle with `req_last`=1, `edt` is high in T4, and `clc` is high in T3 and T4 when `req_clc_en`=1. In a DMA cycle that is not the last one, neither `edt` nor `clc` appears, even if `req_clc_en`=1.
- R6: In a processor cycle (`req_dma`=0), each requested instruction strobe appears as follows: `ioi` and `ioo` in T4 and T5, and `stc`, `clc` and `clf` in T4. In this kind of cycle the direction, last and enable inputs are ignored, and in a DMA cycle the processor instruction inputs are ignored.
- R7: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. It waits in a single slot, and `req_ready` is low while the slot is occupied. The slot is emptied into the next cycle on the edge that enters T2. A request presented while `req_ready` is low is dropped.
- R8: A request that arrives during a cycle does not change that cycle's strobes. `cyc_active` is high for all of T2 to T6 in a cycle that carries an operation, and no strobe other than `enf` and `sir` appears when `cyc_active` is low.
- R9: A last outbound DMA cycle with both enables set drives `ioo`, `stc`, `clc` and `clf` together in T3, and `ioo`, `clc` and `edt` together in T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_dma | input | 1 | 1 = DMA cycle, 0 = processor cycle |
| req_dir_out | input | 1 | DMA direction, 1 = outbound |
| req_last | input | 1 | DMA last-cycle marker |
| req_stc_en | input | 1 | DMA control word: set control allowed |
| req_clc_en | input | 1 | DMA control word: clear control on last cycle |
| req_cpu_ioi | input | 1 | Processor instruction: data input |
| req_cpu_ioo | input | 1 | Processor instruction: data output |
| req_cpu_stc | input | 1 | Processor instruction: set control |
| req_cpu_clc | input | 1 | Processor instruction: clear control |
| req_cpu_clf | input | 1 | Processor instruction: clear flag |
| req_ready | output | 1 | Slot empty, a request can be taken |
| t_phase | output | 5 | One-hot current period, bit 0 = T2 |
| cyc_active | output | 1 | Current cycle carries an operation |
| enf | output | 1 | Flag-enable strobe |
| sir | output | 1 | Set-interrupt-request strobe |
| ioi | output | 1 | Data input strobe |
| ioo | output | 1 | Data output strobe |
| stc | output | 1 | Set control strobe |
| clc | output | 1 | Clear control strobe |
| clf | output | 1 | Clear flag strobe |
| edt | output | 1 | End of data transfer strobe |

## Verification
A wrong period counter shows up at once as a non-one-hot `t_phase` or as a period of the wrong length. In addition, `enf` and `sir` slip out of T2 and T5 within the same cycle. If the latched parameters are corrupted or wrongly reloaded, the wrong strobes appear in the very first period of the cycle that uses them. A mid-cycle reload shows up as a strobe set that changes inside T2 to T6. A slot that never empties or never fills shows at `req_ready` on the next clock, and within one cycle it turns into a missing or an extra operation.

// File: rtl/io_strb_pkg.sv
package io_strb_pkg;

  typedef enum logic [2:0] {
    PH_T2 = 3'd0,
    PH_T3 = 3'd1,
    PH_T4 = 3'd2,
    PH_T5 = 3'd3,
    PH_T6 = 3'd4
  } phase_e;

  typedef struct packed {
    logic dma;
    logic dir_out;
    logic last;
    logic stc_en;
    logic clc_en;
    logic cpu_ioi;
    logic cpu_ioo;
    logic cpu_stc;
    logic cpu_clc;
    logic cpu_clf;
  } cyc_req_t;

  typedef struct packed {
    logic enf;
    logic sir;
    logic ioi;
    logic ioo;
    logic stc;
    logic clc;
    logic clf;
    logic edt;
  } strobe_t;

  function automatic phase_e phase_next(input phase_e p);
    case (p)
      PH_T2:   return PH_T3;
      PH_T3:   return PH_T4;
      PH_T4:   return PH_T5;
      PH_T5:   return PH_T6;
      default: return PH_T2;
    endcase
  endfunction

  function automatic logic [4:0] phase_onehot(input phase_e p);
    return 5'b00001 << p;
  endfunction

  function automatic logic in_window(input phase_e p, input phase_e first, input phase_e last);
    return (p >= first) && (p <= last);
  endfunction

  function automatic strobe_t strobe_decode(input logic active, input cyc_req_t r, input phase_e p);
    strobe_t s;
    logic dma_on, cpu_on, dma_end;
    s = '0;
    s.enf   = (p == PH_T2);
    s.sir   = (p == PH_T5);
    dma_on  = active && r.dma;
    cpu_on  = active && !r.dma;
    dma_end = dma_on && r.last;
    if (dma_on) begin
      s.ioi = !r.dir_out && in_window(p, PH_T2, PH_T3);
      s.ioo =  r.dir_out && in_window(p, PH_T3, PH_T4);
      s.clf = (p == PH_T3);
      s.stc = r.stc_en && (p == PH_T3);
    end
    if (dma_end) begin
      s.edt = (p == PH_T4);
      s.clc = r.clc_en && in_window(p, PH_T3, PH_T4);
    end
    if (cpu_on) begin
      s.ioi = r.cpu_ioi && in_window(p, PH_T4, PH_T5);
      s.ioo = r.cpu_ioo && in_window(p, PH_T4, PH_T5);
      s.stc = r.cpu_stc && (p == PH_T4);
      s.clc = r.cpu_clc && (p == PH_T4);
      s.clf = r.cpu_clf && (p == PH_T4);
    end
    return s;
  endfunction

endpackage

// File: rtl/iocyc_period_seq.sv
module iocyc_period_seq
  import io_strb_pkg::*;
#(
  parameter int PERIOD_CLKS = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase,
  output logic   period_adv,
  output logic   cycle_wrap
);
  localparam int CW = (PERIOD_CLKS > 1) ? $clog2(PERIOD_CLKS) : 1;

  generate
    if (PERIOD_CLKS == 1) begin : g_single
      assign period_adv = 1'b1;
    end else begin : g_prescale
      logic [CW-1:0] sub_q;
      assign period_adv = (sub_q == CW'(PERIOD_CLKS - 1));
      always_ff @(posedge clk) begin
        if (!rst_n)          sub_q <= '0;
        else if (period_adv) sub_q <= '0;
        else                 sub_q <= sub_q + 1'b1;
      end
    end
  endgenerate

  assign cycle_wrap = period_adv && (phase == PH_T6);

  always_ff @(posedge clk) begin
    if (!rst_n)          phase <= PH_T2;
    else if (period_adv) phase <= phase_next(phase);
  end
endmodule

// File: rtl/iocyc_req_slot.sv
module iocyc_req_slot
  import io_strb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  cyc_req_t req_in,
  input  logic     take,
  output logic     full,
  output cyc_req_t slot_q
);
  logic accept;
  assign accept = req_valid && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      slot_q <= '0;
    end else if (accept) begin
      full   <= 1'b1;
      slot_q <= req_in;
    end else if (take) begin
      full   <= 1'b0;
    end
  end
endmodule

// File: rtl/iocyc_active_reg.sv
module iocyc_active_reg
  import io_strb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  logic     next_valid,
  input  cyc_req_t next_req,
  output logic     active,
  output cyc_req_t cur_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cur_req <= '0;
    end else if (load) begin
      active  <= next_valid;
      cur_req <= next_valid ? next_req : '0;
    end
  end
endmodule

// File: rtl/io_cycle_strobe_timer.sv
module io_cycle_strobe_timer
  import io_strb_pkg::*;
#(
  parameter int PERIOD_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_dma,
  input  logic       req_dir_out,
  input  logic       req_last,
  input  logic       req_stc_en,
  input  logic       req_clc_en,
  input  logic       req_cpu_ioi,
  input  logic       req_cpu_ioo,
  input  logic       req_cpu_stc,
  input  logic       req_cpu_clc,
  input  logic       req_cpu_clf,
  output logic       req_ready,
  output logic [4:0] t_phase,
  output logic       cyc_active,
  output logic       enf,
  output logic       sir,
  output logic       ioi,
  output logic       ioo,
  output logic       stc,
  output logic       clc,
  output logic       clf,
  output logic       edt
);
  phase_e   phase;
  logic     period_adv;
  logic     cycle_wrap;
  logic     slot_full;
  cyc_req_t slot_req;
  cyc_req_t cur_req;
  cyc_req_t in_req;
  strobe_t  strb;

  assign in_req = '{dma: req_dma, dir_out: req_dir_out, last: req_last,
                    stc_en: req_stc_en, clc_en: req_clc_en,
                    cpu_ioi: req_cpu_ioi, cpu_ioo: req_cpu_ioo,
                    cpu_stc: req_cpu_stc, cpu_clc: req_cpu_clc,
                    cpu_clf: req_cpu_clf};

  iocyc_period_seq #(.PERIOD_CLKS(PERIOD_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .period_adv(period_adv), .cycle_wrap(cycle_wrap)
  );

  iocyc_req_slot u_slot (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_in(in_req),
    .take(cycle_wrap), .full(slot_full), .slot_q(slot_req)
  );

  iocyc_active_reg u_act (
    .clk(clk), .rst_n(rst_n), .load(cycle_wrap), .next_valid(slot_full),
    .next_req(slot_req), .active(cyc_active), .cur_req(cur_req)
  );

  assign strb      = strobe_decode(cyc_active, cur_req, phase);
  assign req_ready = !slot_full;
  assign t_phase   = phase_onehot(phase);
  assign enf       = strb.enf;
  assign sir       = strb.sir;
  assign ioi       = strb.ioi;
  assign ioo       = strb.ioo;
  assign stc       = strb.stc;
  assign clc       = strb.clc;
  assign clf       = strb.clf;
  assign edt       = strb.edt;
endmodule

// File: rtl/io_cycle_strobe_timer_chk.sv
module io_cycle_strobe_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       period_adv,
  input logic       cycle_wrap,
  input logic       req_valid,
  input logic       req_ready,
  input logic [4:0] t_phase,
  input logic       cyc_active,
  input logic       enf,
  input logic       sir,
  input logic       ioi,
  input logic       ioo,
  input logic       stc,
  input logic       clc,
  input logic       clf,
  input logic       edt
);
  assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(t_phase) == 1);
  assert_wrap_to_t2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (t_phase[4] && period_adv) |=> t_phase[0]);
  assert_phase_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !period_adv |=> $stable(t_phase));
  assert_enf_in_t2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enf |-> t_phase[0]);
  assert_sir_in_t5_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sir |-> t_phase[3]);
  assert_edt_in_t4_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edt |-> (t_phase[2] && cyc_active));
  assert_strobe_needs_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ioi || ioo || stc || clc || clf || edt) |-> cyc_active);
  assert_active_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_wrap |=> $stable(cyc_active));
  assert_slot_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cycle_wrap) |=> !req_ready);
endmodule

bind io_cycle_strobe_timer io_cycle_strobe_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .period_adv(period_adv), .cycle_wrap(cycle_wrap),
  .req_valid(req_valid), .req_ready(req_ready), .t_phase(t_phase),
  .cyc_active(cyc_active), .enf(enf), .sir(sir), .ioi(ioi), .ioo(ioo),
  .stc(stc), .clc(clc), .clf(clf), .edt(edt)
);

// File: tb/io_cycle_strobe_timer_tb.sv
module io_cycle_strobe_timer_tb;
  localparam int P   = 2;
  localparam int CYC = 5 * P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_dma = 0, req_dir_out = 0, req_last = 0;
  logic req_stc_en = 0, req_clc_en = 0;
  logic req_cpu_ioi = 0, req_cpu_ioo = 0, req_cpu_stc = 0, req_cpu_clc = 0, req_cpu_clf = 0;
  logic req_ready, cyc_active, enf, sir, ioi, ioo, stc, clc, clf, edt;
  logic [4:0] t_phase;

  typedef struct {
    bit dma, out, last, stc_en, clc_en;
    bit c_ioi, c_ioo, c_stc, c_clc, c_clf;
    int cyc;
    string tag;
  } item_t;

  item_t q[$];
  int n = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  io_cycle_strobe_timer #(.PERIOD_CLKS(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dma(req_dma),
    .req_dir_out(req_dir_out), .req_last(req_last), .req_stc_en(req_stc_en),
    .req_clc_en(req_clc_en), .req_cpu_ioi(req_cpu_ioi), .req_cpu_ioo(req_cpu_ioo),
    .req_cpu_stc(req_cpu_stc), .req_cpu_clc(req_cpu_clc), .req_cpu_clf(req_cpu_clf),
    .req_ready(req_ready), .t_phase(t_phase), .cyc_active(cyc_active),
    .enf(enf), .sir(sir), .ioi(ioi), .ioo(ioo), .stc(stc), .clc(clc),
    .clf(clf), .edt(edt)
  );

  always @(posedge clk) if (rst_n) n <= n + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (clk %0d)", tag, act, exp, n);
    end
  endtask

  // expected {enf,sir,ioi,ioo,stc,clc,clf,edt,cyc_active}
  function automatic logic [8:0] expv(input bit has, input item_t it, input int per);
    logic e_enf, e_sir, e_ioi, e_ioo, e_stc, e_clc, e_clf, e_edt;
    e_enf = (per == 0); e_sir = (per == 3);
    {e_ioi, e_ioo, e_stc, e_clc, e_clf, e_edt} = '0;
    if (has && it.dma) begin
      case (per)
        0: e_ioi = !it.out;
        1: begin
          e_ioi = !it.out; e_ioo = it.out; e_clf = 1'b1;
          e_stc = it.stc_en; e_clc = it.last && it.clc_en;
        end
        2: begin
          e_ioo = it.out; e_clc = it.last && it.clc_en; e_edt = it.last;
        end
        default: ;
      endcase
    end else if (has) begin
      case (per)
        2: begin
          e_ioi = it.c_ioi; e_ioo = it.c_ioo;
          e_stc = it.c_stc; e_clc = it.c_clc; e_clf = it.c_clf;
        end
        3: begin e_ioi = it.c_ioi; e_ioo = it.c_ioo; end
        default: ;
      endcase
    end
    return {e_enf, e_sir, e_ioi, e_ioo, e_stc, e_clc, e_clf, e_edt, has};
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int cyc, per;
      bit has;
      item_t it;
      cyc = n / CYC;
      per = (n / P) % 5;
      has = (q.size() > 0) && (q[0].cyc == cyc);
      if (has) it = q[0];
      else begin it = '{default: 0}; it.tag = "R2 R8 idle"; end
      check({"R1 phase ", it.tag}, 32'(t_phase), 32'(5'b1 << per));
      check(it.tag, 32'({enf, sir, ioi, ioo, stc, clc, clf, edt, cyc_active}),
            32'(expv(has, it, per)));
      if (has && per == 4 && (n % P) == P - 1) void'(q.pop_front());
    end
  end

  task automatic drive(input item_t it);
    req_dma = it.dma; req_dir_out = it.out; req_last = it.last;
    req_stc_en = it.stc_en; req_clc_en = it.clc_en;
    req_cpu_ioi = it.c_ioi; req_cpu_ioo = it.c_ioo; req_cpu_stc = it.c_stc;
    req_cpu_clc = it.c_clc; req_cpu_clf = it.c_clf;
  endtask

  // issue in T3 of the current cycle; executes in the next cycle
  task automatic issue(input item_t it);
    do @(negedge clk); while ((n % CYC) != P);
    check("R7 ready before request", 32'(req_ready), 32'd1);
    it.cyc = n / CYC + 1;
    q.push_back(it);
    drive(it);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic item_t mk(input bit dma, out, last, se, ce, ci, co, cs, cc, cf, input string tag);
    item_t it;
    it.dma = dma; it.out = out; it.last = last; it.stc_en = se; it.clc_en = ce;
    it.c_ioi = ci; it.c_ioo = co; it.c_stc = cs; it.c_clc = cc; it.c_clf = cf;
    it.cyc = 0; it.tag = tag;
    return it;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // reset state R1
    check("R1 reset phase", 32'(t_phase), 32'd1);
    check("R1 reset strobes", 32'({enf, sir, ioi, ioo, stc, clc, clf, edt, cyc_active}),
          32'(9'b100000000));
    check("R7 reset ready", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    repeat (CYC) @(negedge clk);
    issue(mk(1,0,0,1,0, 0,0,0,0,0, "R3 R4 dma in stc"));
    issue(mk(1,1,0,0,1, 0,0,0,0,0, "R3 R5 dma out not-last clc_en"));
    issue(mk(1,0,1,0,1, 0,0,0,0,0, "R5 dma in last clc"));
    issue(mk(1,1,1,1,1, 0,0,0,0,0, "R9 dma out last all"));
    issue(mk(0,1,1,1,1, 1,0,1,0,1, "R6 cpu ioi stc clf"));
    issue(mk(0,0,0,0,0, 0,1,0,1,0, "R6 cpu ioo clc"));
    issue(mk(1,1,0,0,0, 1,1,1,1,1, "R6 dma ignores cpu bits"));
    issue(mk(1,0,1,1,0, 0,0,0,0,0, "R4 R5 dma in last stc"));
    // drop test R7: second request while slot occupied
    issue(mk(0,0,0,0,0, 1,1,1,1,1, "R7 cpu all"));
    check("R7 ready low while slot full", 32'(req_ready), 32'd0);
    drive(mk(1,1,1,1,1, 0,0,0,0,0, "dropped"));
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3 * CYC) @(negedge clk);
    check("R7 queue drained", 32'(q.size()), 32'd0);
    check("R7 ready after drain", 32'(req_ready), 32'd1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule